// File: doc/BRIEF.md
# MAC Interrupt and Control Register Bank

This block is the software-visible register bank of a small Ethernet MAC. A processor reaches it through a plain 32-bit word bus with a byte address, a write enable, write data and combinational read data. The bank keeps the raw interrupt status and its enable mask, the receive and transmit control words, the transmit threshold, three management registers (control, clock divider, transmit data) and the six-byte station address. It drives these settings to the MAC datapath as ports.

The datapath reports events through one set-pulse per interrupt source. The bank combines raw status with the mask into a single level-sensitive interrupt line. A few writes have side effects, and each of these is signalled by a one-cycle strobe: flushing the transmit FIFO, flushing the receive FIFO, and a manual transmit request. The FIFOs and the management serial engine are separate blocks that act on these strobes and settings.

Top module: `mac_regbank`

## Requirements
- R1: Raw status bit i is set in the cycle after `evt_set[i]` is high. The bit positions are: RX 0, TX error 1, TX empty 2, FIFO overrun 3, RX error 4, management done 5, PHY 6. The raw status reads back at offset 0x00 in bits 6:0.
- R2: `irq` is high exactly when the AND of raw status and mask is nonzero. The mask is written and read at offset 0x04 and keeps bits 6:0.
- R3: A write to offset 0x00 clears each raw status bit whose write-data bit is one. When a set-pulse and a clear hit the same bit in the same cycle, the bit ends set.
- R4: A write to offset 0x00 with data bit 1 set drives `tx_fifo_flush` high for the one cycle after the write edge. This happens whatever the status holds.
- R5: The receive control register at offset 0x08 keeps write-data bits 7:0 and appears on `rx_ctl`. A write with bit 4 set drives `rx_fifo_flush` high for the one cycle after the write edge.
- R6: After reset: mask = 0x7F, receive control = 0x08, threshold = 0x3F, management divider = 0x80. Every other register is zero, and all strobes and `irq` are low.
- R7: A write to management control at offset 0x20 stores data bits 7:0 with bit 0 forced to zero, so a started operation reads back as finished.
- R8: The management divider at offset 0x24 and the management transmit data at offset 0x2C each keep only data bits 7:0.
- R9: The station address is little-endian. Offset 0x14 holds bytes 0 to 3 (byte 0 in bits 7:0). Offset 0x18 holds bytes 4 and 5 in bits 15:0, and its upper bits read zero. `station_addr[7:0]` is byte 0.
- R10: A write to offset 0x38 with data bit 0 set drives `tx_start` high for the one cycle after the write edge. Offsets 0x28, 0x38 and 0x3C read zero.
- R11: Every other offset reads zero, and a write to it changes no register and raises no strobe. Address bits 1:0 are ignored.
- R12: The transmit control register at offset 0x0C keeps data bits 7:0. The threshold at offset 0x1C keeps data bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| evt_set | input | NUM_SRC (7) | Per-source interrupt set-pulses from the datapath |
| irq | output | 1 | Level interrupt |
| tx_fifo_flush | output | 1 | One-cycle transmit FIFO reset strobe |
| rx_fifo_flush | output | 1 | One-cycle receive FIFO reset strobe |
| tx_start | output | 1 | One-cycle manual transmit strobe |
| rx_ctl | output | CTL_W (8) | Receive control word |
| tx_ctl | output | CTL_W (8) | Transmit control word |
| tx_thresh | output | THR_W (6) | Transmit threshold |
| mgmt_ctl | output | CTL_W (8) | Management control |
| mgmt_div | output | CTL_W (8) | Management clock divider |
| mgmt_txd | output | CTL_W (8) | Management transmit data |
| station_addr | output | 48 | Station address, byte 0 in bits 7:0 |

## Verification
A write or set-pulse applied before a rising edge updates its register at that edge. Read data is combinational from the registers, so the new value is seen at the following falling edge with the address still held. The same holds for `irq` and the setting ports. Each strobe is registered from the write, so it is high only during the cycle after the write edge and low again one edge later. The bench drives at the falling edge, advances its own model at the rising edge, and compares every output at the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/mac_reg_pkg.sv
package mac_reg_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 7;
    localparam int CTL_W   = 8;
    localparam int THR_W   = 6;
    localparam int SADR_BYTES = 6;

    // word indices (byte offset >> 2)
    localparam logic [5:0] W_STAT  = 6'h00;
    localparam logic [5:0] W_MASK  = 6'h01;
    localparam logic [5:0] W_RCTL  = 6'h02;
    localparam logic [5:0] W_TCTL  = 6'h03;
    localparam logic [5:0] W_SADR0 = 6'h05;
    localparam logic [5:0] W_SADR1 = 6'h06;
    localparam logic [5:0] W_THR   = 6'h07;
    localparam logic [5:0] W_MCTL  = 6'h08;
    localparam logic [5:0] W_MDIV  = 6'h09;
    localparam logic [5:0] W_MTXD  = 6'h0B;
    localparam logic [5:0] W_XMIT  = 6'h0E;

    // interrupt source bit positions
    localparam int IRQ_RX    = 0;
    localparam int IRQ_TXERR = 1;
    localparam int IRQ_TXEMP = 2;
    localparam int IRQ_FOV   = 3;
    localparam int IRQ_RXERR = 4;
    localparam int IRQ_MDONE = 5;
    localparam int IRQ_PHY   = 6;

    // side-effect bit positions
    localparam int RCTL_FLUSH_BIT = 4;
    localparam int XMIT_GO_BIT    = 0;
    localparam int MCTL_START_BIT = 0;

    // reset values
    localparam logic [NUM_SRC-1:0] MASK_RST = {NUM_SRC{1'b1}};
    localparam logic [CTL_W-1:0]   RCTL_RST = 8'h08;
    localparam logic [THR_W-1:0]   THR_RST  = {THR_W{1'b1}};
    localparam logic [CTL_W-1:0]   MDIV_RST = 8'h80;

    typedef struct packed {
        logic stat;
        logic mask;
        logic rctl;
        logic tctl;
        logic sadr0;
        logic sadr1;
        logic thr;
        logic mctl;
        logic mdiv;
        logic mtxd;
        logic xmit;
    } wr_sel_t;

    function automatic wr_sel_t decode_write(input logic [5:0] idx, input logic we);
        wr_sel_t s;
        s.stat  = we && (idx == W_STAT);
        s.mask  = we && (idx == W_MASK);
        s.rctl  = we && (idx == W_RCTL);
        s.tctl  = we && (idx == W_TCTL);
        s.sadr0 = we && (idx == W_SADR0);
        s.sadr1 = we && (idx == W_SADR1);
        s.thr   = we && (idx == W_THR);
        s.mctl  = we && (idx == W_MCTL);
        s.mdiv  = we && (idx == W_MDIV);
        s.mtxd  = we && (idx == W_MTXD);
        s.xmit  = we && (idx == W_XMIT);
        return s;
    endfunction

endpackage

// File: rtl/cfg_field.sv
module cfg_field #(
    parameter int         W    = 8,
    parameter logic [W-1:0] RSTV = '0,
    parameter logic [W-1:0] KEEP = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= RSTV;
        else if (we)
            q <= d & KEEP;
    end

    // R12: a loaded field holds the written value under its keep mask
    a_r12_field_load: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == ($past(d) & KEEP)));

endmodule

// File: rtl/irq_unit.sv
module irq_unit
    import mac_reg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ack_we,
    input  logic               mask_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] set_i,
    output logic [NUM_SRC-1:0] raw_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               irq_o,
    output logic               tx_flush_o
);

    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] raw_next;

    always_comb begin
        clr_vec  = ack_we ? wdata[NUM_SRC-1:0] : '0;
        // set beats clear so no event is lost
        raw_next = (raw_o & ~clr_vec) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_o      <= '0;
            mask_o     <= MASK_RST;
            tx_flush_o <= 1'b0;
        end else begin
            raw_o      <= raw_next;
            if (mask_we)
                mask_o <= wdata[NUM_SRC-1:0];
            tx_flush_o <= ack_we && wdata[IRQ_TXERR];
        end
    end

    assign irq_o = |(raw_o & mask_o);

    // R1 and R3: every pulsed source is set one edge later, even under a clear
    a_r1_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((raw_o & $past(set_i)) == $past(set_i)));

    // R3: acknowledged bits without a concurrent set are cleared
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_we && ((wdata[NUM_SRC-1:0] & ~set_i) != '0))
        |=> ((raw_o & $past(wdata[NUM_SRC-1:0] & ~set_i)) == '0));

    // R4: acknowledging the TX error bit flushes the TX FIFO for one cycle
    a_r4_tx_flush: assert property (@(posedge clk) disable iff (rst)
        (ack_we && wdata[IRQ_TXERR]) |=> tx_flush_o);

    a_r4_tx_flush_only: assert property (@(posedge clk) disable iff (rst)
        !(ack_we && wdata[IRQ_TXERR]) |=> !tx_flush_o);

    // R2: with all sources masked the line stays low
    a_r2_mask_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_o == '0) |-> !irq_o);

endmodule

// File: rtl/ctl_unit.sv
module ctl_unit
    import mac_reg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  wr_sel_t                 sel,
    input  logic [DATA_W-1:0]       wdata,
    output logic [CTL_W-1:0]        rctl_o,
    output logic [CTL_W-1:0]        tctl_o,
    output logic [THR_W-1:0]        thr_o,
    output logic [CTL_W-1:0]        mctl_o,
    output logic [CTL_W-1:0]        mdiv_o,
    output logic [CTL_W-1:0]        mtxd_o,
    output logic [8*SADR_BYTES-1:0] sadr_o,
    output logic                    rx_flush_o,
    output logic                    tx_go_o
);

    localparam logic [CTL_W-1:0] MCTL_KEEP = ~(CTL_W'(1) << MCTL_START_BIT);
    localparam int LOW_WORD_BYTES = DATA_W / 8;

    cfg_field #(.W(CTL_W), .RSTV(RCTL_RST)) u_rctl (
        .clk(clk), .rst(rst), .we(sel.rctl), .d(wdata[CTL_W-1:0]), .q(rctl_o));

    cfg_field #(.W(CTL_W)) u_tctl (
        .clk(clk), .rst(rst), .we(sel.tctl), .d(wdata[CTL_W-1:0]), .q(tctl_o));

    cfg_field #(.W(THR_W), .RSTV(THR_RST)) u_thr (
        .clk(clk), .rst(rst), .we(sel.thr), .d(wdata[THR_W-1:0]), .q(thr_o));

    cfg_field #(.W(CTL_W), .KEEP(MCTL_KEEP)) u_mctl (
        .clk(clk), .rst(rst), .we(sel.mctl), .d(wdata[CTL_W-1:0]), .q(mctl_o));

    cfg_field #(.W(CTL_W), .RSTV(MDIV_RST)) u_mdiv (
        .clk(clk), .rst(rst), .we(sel.mdiv), .d(wdata[CTL_W-1:0]), .q(mdiv_o));

    cfg_field #(.W(CTL_W)) u_mtxd (
        .clk(clk), .rst(rst), .we(sel.mtxd), .d(wdata[CTL_W-1:0]), .q(mtxd_o));

    // station address: bytes in the low word come from one offset, the rest from the next
    for (genvar b = 0; b < SADR_BYTES; b++) begin : g_sadr
        localparam int LANE = (b < LOW_WORD_BYTES) ? b : b - LOW_WORD_BYTES;
        logic byte_we;
        assign byte_we = (b < LOW_WORD_BYTES) ? sel.sadr0 : sel.sadr1;
        cfg_field #(.W(8)) u_byte (
            .clk(clk), .rst(rst), .we(byte_we),
            .d(wdata[8*LANE +: 8]), .q(sadr_o[8*b +: 8]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_flush_o <= 1'b0;
            tx_go_o    <= 1'b0;
        end else begin
            rx_flush_o <= sel.rctl && wdata[RCTL_FLUSH_BIT];
            tx_go_o    <= sel.xmit && wdata[XMIT_GO_BIT];
        end
    end

    // R5: RX FIFO flush strobe follows exactly the flagged control write
    a_r5_rx_flush: assert property (@(posedge clk) disable iff (rst)
        (sel.rctl && wdata[RCTL_FLUSH_BIT]) |=> rx_flush_o);

    a_r5_rx_flush_only: assert property (@(posedge clk) disable iff (rst)
        !(sel.rctl && wdata[RCTL_FLUSH_BIT]) |=> !rx_flush_o);

    // R10: manual transmit strobe
    a_r10_tx_go: assert property (@(posedge clk) disable iff (rst)
        (sel.xmit && wdata[XMIT_GO_BIT]) |=> tx_go_o);

    a_r10_tx_go_only: assert property (@(posedge clk) disable iff (rst)
        !(sel.xmit && wdata[XMIT_GO_BIT]) |=> !tx_go_o);

    // R7: a management start written as one reads back finished
    a_r7_start_clear: assert property (@(posedge clk) disable iff (rst)
        sel.mctl |=> !mctl_o[MCTL_START_BIT]);

endmodule

// File: rtl/rd_mux.sv
module rd_mux
    import mac_reg_pkg::*;
(
    input  logic [5:0]              idx,
    input  logic [NUM_SRC-1:0]      raw,
    input  logic [NUM_SRC-1:0]      mask,
    input  logic [CTL_W-1:0]        rctl,
    input  logic [CTL_W-1:0]        tctl,
    input  logic [THR_W-1:0]        thr,
    input  logic [CTL_W-1:0]        mctl,
    input  logic [CTL_W-1:0]        mdiv,
    input  logic [CTL_W-1:0]        mtxd,
    input  logic [8*SADR_BYTES-1:0] sadr,
    output logic [DATA_W-1:0]       rdata
);

    localparam int LOW_W = DATA_W;
    localparam int HI_W  = 8*SADR_BYTES - DATA_W;

    always_comb begin
        rdata = '0;
        unique case (idx)
            W_STAT:  rdata = DATA_W'(raw);
            W_MASK:  rdata = DATA_W'(mask);
            W_RCTL:  rdata = DATA_W'(rctl);
            W_TCTL:  rdata = DATA_W'(tctl);
            W_SADR0: rdata = sadr[LOW_W-1:0];
            W_SADR1: rdata = DATA_W'(sadr[LOW_W +: HI_W]);
            W_THR:   rdata = DATA_W'(thr);
            W_MCTL:  rdata = DATA_W'(mctl);
            W_MDIV:  rdata = DATA_W'(mdiv);
            W_MTXD:  rdata = DATA_W'(mtxd);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/mac_regbank.sv
module mac_regbank
    import mac_reg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NUM_SRC-1:0]      evt_set,
    output logic                    irq,
    output logic                    tx_fifo_flush,
    output logic                    rx_fifo_flush,
    output logic                    tx_start,
    output logic [CTL_W-1:0]        rx_ctl,
    output logic [CTL_W-1:0]        tx_ctl,
    output logic [THR_W-1:0]        tx_thresh,
    output logic [CTL_W-1:0]        mgmt_ctl,
    output logic [CTL_W-1:0]        mgmt_div,
    output logic [CTL_W-1:0]        mgmt_txd,
    output logic [8*SADR_BYTES-1:0] station_addr
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]   word_idx;
    logic               in_window;
    logic [5:0]         map_idx;
    wr_sel_t            sel;
    logic [NUM_SRC-1:0] raw_stat;
    logic [NUM_SRC-1:0] irq_mask;
    logic [DATA_W-1:0]  mux_data;

    assign word_idx  = bus_addr[ADDR_W-1:2];
    // the map occupies the first 64 words; above that nothing is decoded
    assign in_window = (32'(word_idx) < 64);
    assign map_idx   = word_idx[5:0];
    assign sel       = decode_write(map_idx, bus_we && in_window);

    irq_unit u_irq (
        .clk        (clk),
        .rst        (rst),
        .ack_we     (sel.stat),
        .mask_we    (sel.mask),
        .wdata      (bus_wdata),
        .set_i      (evt_set),
        .raw_o      (raw_stat),
        .mask_o     (irq_mask),
        .irq_o      (irq),
        .tx_flush_o (tx_fifo_flush)
    );

    ctl_unit u_ctl (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel),
        .wdata      (bus_wdata),
        .rctl_o     (rx_ctl),
        .tctl_o     (tx_ctl),
        .thr_o      (tx_thresh),
        .mctl_o     (mgmt_ctl),
        .mdiv_o     (mgmt_div),
        .mtxd_o     (mgmt_txd),
        .sadr_o     (station_addr),
        .rx_flush_o (rx_fifo_flush),
        .tx_go_o    (tx_start)
    );

    rd_mux u_rd (
        .idx   (map_idx),
        .raw   (raw_stat),
        .mask  (irq_mask),
        .rctl  (rx_ctl),
        .tctl  (tx_ctl),
        .thr   (tx_thresh),
        .mctl  (mgmt_ctl),
        .mdiv  (mgmt_div),
        .mtxd  (mgmt_txd),
        .sadr  (station_addr),
        .rdata (mux_data)
    );

    assign bus_rdata = in_window ? mux_data : '0;

    // R11: a write outside the map leaves every setting where it was
    a_r11_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !in_window && (evt_set == '0))
        |=> ($stable(raw_stat) && $stable(irq_mask) && $stable(rx_ctl) && $stable(station_addr)));

endmodule

// File: tb/sim_mac_regbank.sv
module sim_mac_regbank;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  evt_set = '0;
    logic        irq, tx_fifo_flush, rx_fifo_flush, tx_start;
    logic [7:0]  rx_ctl, tx_ctl, mgmt_ctl, mgmt_div, mgmt_txd;
    logic [5:0]  tx_thresh;
    logic [47:0] station_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_regbank u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
        .irq(irq), .tx_fifo_flush(tx_fifo_flush), .rx_fifo_flush(rx_fifo_flush),
        .tx_start(tx_start), .rx_ctl(rx_ctl), .tx_ctl(tx_ctl), .tx_thresh(tx_thresh),
        .mgmt_ctl(mgmt_ctl), .mgmt_div(mgmt_div), .mgmt_txd(mgmt_txd),
        .station_addr(station_addr)
    );

    // behavioural model state
    logic [6:0]  m_raw, m_mask;
    logic [7:0]  m_rctl, m_tctl, m_mctl, m_mdiv, m_mtxd;
    logic [5:0]  m_thr;
    logic [47:0] m_sadr;
    logic        m_txf, m_rxf, m_go;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (addr %0h)", tag, act, exp, bus_addr);
        end
    endtask

    function automatic string tag_for(input logic [7:0] a);
        case (a[7:2])
            6'h00: return "R1";
            6'h01: return "R2";
            6'h02: return "R5";
            6'h03, 6'h07: return "R12";
            6'h05, 6'h06: return "R9";
            6'h08: return "R7";
            6'h09, 6'h0B: return "R8";
            6'h0A, 6'h0E, 6'h0F: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a[7:2])
            6'h00: return {25'd0, m_raw};
            6'h01: return {25'd0, m_mask};
            6'h02: return {24'd0, m_rctl};
            6'h03: return {24'd0, m_tctl};
            6'h05: return m_sadr[31:0];
            6'h06: return {16'd0, m_sadr[47:32]};
            6'h07: return {26'd0, m_thr};
            6'h08: return {24'd0, m_mctl};
            6'h09: return {24'd0, m_mdiv};
            6'h0B: return {24'd0, m_mtxd};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_edge();
        logic [5:0] i;
        i = bus_addr[7:2];
        if (rst) begin
            m_raw = '0; m_mask = 7'h7F; m_rctl = 8'h08; m_tctl = '0;
            m_thr = 6'h3F; m_mctl = '0; m_mdiv = 8'h80; m_mtxd = '0;
            m_sadr = '0; m_txf = 0; m_rxf = 0; m_go = 0;
        end else begin
            m_txf = 0; m_rxf = 0; m_go = 0;
            if (bus_we && i == 6'h00) begin
                m_raw = m_raw & ~bus_wdata[6:0];
                m_txf = bus_wdata[1];
            end
            m_raw = m_raw | evt_set;
            if (bus_we) begin
                case (i)
                    6'h01: m_mask = bus_wdata[6:0];
                    6'h02: begin m_rctl = bus_wdata[7:0]; m_rxf = bus_wdata[4]; end
                    6'h03: m_tctl = bus_wdata[7:0];
                    6'h05: m_sadr[31:0] = bus_wdata;
                    6'h06: m_sadr[47:32] = bus_wdata[15:0];
                    6'h07: m_thr = bus_wdata[5:0];
                    6'h08: m_mctl = bus_wdata[7:0] & 8'hFE;
                    6'h09: m_mdiv = bus_wdata[7:0];
                    6'h0B: m_mtxd = bus_wdata[7:0];
                    6'h0E: m_go = bus_wdata[0];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic compare_all();
        chk(tag_for(bus_addr), bus_rdata, exp_read(bus_addr));
        chk("R2 irq", irq, |(m_raw & m_mask));
        chk("R4 tx_fifo_flush", tx_fifo_flush, m_txf);
        chk("R5 rx_fifo_flush", rx_fifo_flush, m_rxf);
        chk("R10 tx_start", tx_start, m_go);
        chk("R5 rx_ctl", rx_ctl, m_rctl);
        chk("R12 tx_ctl", tx_ctl, m_tctl);
        chk("R12 tx_thresh", tx_thresh, m_thr);
        chk("R7 mgmt_ctl", mgmt_ctl, m_mctl);
        chk("R8 mgmt_div", mgmt_div, m_mdiv);
        chk("R8 mgmt_txd", mgmt_txd, m_mtxd);
        chk("R9 station_addr", station_addr, m_sadr);
    endtask

    // drive at the falling edge, model at the rising edge, compare at the next falling edge
    task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d, input logic [6:0] s);
        bus_addr = a; bus_we = w; bus_wdata = d; evt_set = s;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        @(negedge clk);
        rst = 1'b1;
        step(8'h00, 1'b0, 32'h0, 7'h00);
        step(8'h00, 1'b0, 32'h0, 7'h00);
        // R6: reset values at the ports
        chk("R6 mask/irq", irq, 1'b0);
        chk("R6 rx_ctl", rx_ctl, 8'h08);
        chk("R6 tx_thresh", tx_thresh, 6'h3F);
        chk("R6 mgmt_div", mgmt_div, 8'h80);
        chk("R6 strobes", {tx_fifo_flush, rx_fifo_flush, tx_start}, 3'b000);
        rst = 1'b0;
        for (int k = 0; k < 16; k++) step(8'(k * 4), 1'b0, 32'h0, 7'h00);
        chk("R6 mask read", exp_read(8'h04), 32'h7F);
        step(8'h04, 1'b0, 32'h0, 7'h00);
        chk("R6 mask port read", bus_rdata, 32'h7F);

        // R1, R2: events and mask
        step(8'h00, 1'b0, 32'h0, 7'h01);
        chk("R1 RX bit", bus_rdata, 32'h01);
        chk("R2 irq on", irq, 1'b1);
        step(8'h04, 1'b1, 32'h0, 7'h40);
        chk("R2 irq masked", irq, 1'b0);
        step(8'h04, 1'b1, 32'hFFFF_FF40, 7'h00);
        chk("R2 PHY enabled", irq, 1'b1);
        // R3: set wins over same-cycle ack
        step(8'h00, 1'b1, 32'h0000_0041, 7'h01);
        step(8'h00, 1'b0, 32'h0, 7'h00);
        chk("R3 set wins", bus_rdata, 32'h01);
        // R3, R4: full ack, TX flush
        step(8'h00, 1'b1, 32'hFFFF_FFFF, 7'h00);
        chk("R4 flush", tx_fifo_flush, 1'b1);
        step(8'h00, 1'b1, 32'h0000_0002, 7'h00);
        chk("R4 flush on empty status", tx_fifo_flush, 1'b1);
        step(8'h00, 1'b0, 32'h0, 7'h00);
        chk("R4 flush one cycle", tx_fifo_flush, 1'b0);
        chk("R3 cleared", bus_rdata, 32'h0);
        // R5
        step(8'h08, 1'b1, 32'hFFFF_FF18, 7'h00);
        chk("R5 rx flush", rx_fifo_flush, 1'b1);
        step(8'h08, 1'b1, 32'h0000_0001, 7'h00);
        chk("R5 no flush", rx_fifo_flush, 1'b0);
        // R7, R8, R12
        step(8'h20, 1'b1, 32'hFFFF_FFFF, 7'h00);
        chk("R7 start cleared", bus_rdata, 32'hFE);
        step(8'h2C, 1'b1, 32'h1234_5678, 7'h00);
        chk("R8 txd low byte", bus_rdata, 32'h78);
        step(8'h24, 1'b1, 32'hCAFE_00AB, 7'h00);
        step(8'h1C, 1'b1, 32'hFFFF_FFFF, 7'h00);
        chk("R12 thr width", bus_rdata, 32'h3F);
        step(8'h0C, 1'b1, 32'hA5A5_A55A, 7'h00);
        // R9
        step(8'h14, 1'b1, 32'h4433_2211, 7'h00);
        step(8'h18, 1'b1, 32'hDEAD_6655, 7'h00);
        chk("R9 byte order", station_addr, 48'h6655_4433_2211);
        chk("R9 upper read", bus_rdata, 32'h0000_6655);
        // R10
        step(8'h38, 1'b1, 32'h0000_0001, 7'h00);
        chk("R10 tx_start", tx_start, 1'b1);
        chk("R10 0x38 reads zero", bus_rdata, 32'h0);
        step(8'h38, 1'b1, 32'hFFFF_FFFE, 7'h00);
        chk("R10 no start", tx_start, 1'b0);
        // R10, R11: ignored writes, checked at all outputs each step
        step(8'h28, 1'b1, 32'hFFFF_FFFF, 7'h00);
        step(8'h3C, 1'b1, 32'hFFFF_FFFF, 7'h00);
        step(8'h30, 1'b1, 32'hFFFF_FFFF, 7'h00);
        step(8'h10, 1'b1, 32'hFFFF_FFFF, 7'h00);
        step(8'h40, 1'b1, 32'hFFFF_FFFF, 7'h00);
        step(8'hFC, 1'b1, 32'hFFFF_FFFF, 7'h00);
        for (int k = 0; k < 64; k++) step(8'(k * 4 + (k % 4)), 1'b0, 32'h0, 7'h00);

        // randomised traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] a;
            logic [6:0] s;
            a = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 64);
            s = ($urandom % 4 == 0) ? 7'($urandom) : 7'h00;
            if (n == 2000) rst = 1'b1;
            if (n == 2002) rst = 1'b0;
            step(a, 1'($urandom), $urandom, s);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule